// File: doc/BRIEF.md
# Segment Address Translator with Bounds Check

This block maps a logical address into a physical address for a single active memory segment. Software programs three descriptor registers: a base, a lower limit and an upper limit. On each request the block adds the base to the logical address. It then tests the sum against both limits. One cycle later it returns either the physical address or a range-error flag.

The descriptor is loaded through a simple register write port. A one-hot select is not used. Instead, a two-bit code picks the target register, so a descriptor change costs one write per field. Requests use a single-cycle valid strobe and need no back-pressure. The translator accepts one request per cycle, and requests may arrive back to back.

Top module: `seg_xlate`

## Requirements
- R1: After reset, resp_valid, phys_addr and range_err are 0, and the descriptor holds base 0, lower limit 0 and upper limit all ones. A request made right after reset therefore returns its logical address unchanged with no error.
- R2: A response (resp_valid=1) appears in the cycle after each cycle with req_valid=1, and in no other cycle. While resp_valid is 0, phys_addr and range_err are 0. Back-to-back requests give back-to-back responses.
- R3: When the request is within range, phys_addr equals the logical address plus the base, and range_err is 0.
- R4: The limits are inclusive. A sum equal to the lower limit, or equal to the upper limit, is legal.
- R5: A sum below the lower limit gives range_err=1 with phys_addr=0.
- R6: A sum above the upper limit gives range_err=1 with phys_addr=0.
- R7: A carry out of the 32-bit base-plus-offset addition gives range_err=1 with phys_addr=0, even if the truncated sum lies within the limits.
- R8: A descriptor write with cfg_we=1 uses cfg_sel to pick the register: 0 selects the base, 1 the lower limit, 2 the upper limit. The write affects requests from the following cycle on. A request in the same cycle as the write uses the old value.
- R9: A write with cfg_sel=3 changes no descriptor register.
- R10: If the lower limit is above the upper limit, every request returns range_err=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | 2 | Descriptor field code (0 base, 1 lower, 2 upper, 3 none) |
| cfg_wdata | input | 32 | Descriptor write data |
| req_valid | input | 1 | Translation request strobe |
| req_laddr | input | 32 | Logical address of the request |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| phys_addr | output | 32 | Translated address, 0 on error or when idle |
| range_err | output | 1 | Range error for the responded request |

## Verification
A corrupted descriptor register stays invisible until a request is made. It then shows as a wrong phys_addr or a wrong range_err in the very next cycle. For this reason the bench reprograms all three fields before each table vector, and places sums exactly on the limits. Faults in the limit comparators or the carry path flip range_err in the response cycle, and they also force phys_addr to zero. A fault in write timing is caught by a request issued in the same cycle as the write, followed by one issued in the next cycle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int ADDR_W_DEF = 32;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_HIGH = 2'd2,
    SEL_NONE = 2'd3
  } desc_sel_e;

  localparam int NUM_FIELDS = 3;
endpackage

// File: rtl/seg_desc_regs.sv
module seg_desc_regs
  import seg_xlate_pkg::*;
#(
  parameter int AW = ADDR_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] low_o,
  output logic [AW-1:0] high_o
);
  logic [AW-1:0] field_q [NUM_FIELDS];

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [AW-1:0] RST_VAL = (i == int'(SEL_HIGH)) ? '1 : '0;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        field_q[i] <= RST_VAL;
      end else if (we && (sel == 2'(i))) begin
        field_q[i] <= wdata;
      end
    end
  end

  assign base_o = field_q[int'(SEL_BASE)];
  assign low_o  = field_q[int'(SEL_LOW)];
  assign high_o = field_q[int'(SEL_HIGH)];
endmodule

// File: rtl/seg_xlate_core.sv
module seg_xlate_core
  import seg_xlate_pkg::*;
#(
  parameter int AW = ADDR_W_DEF
) (
  input  logic [AW-1:0] laddr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] low,
  input  logic [AW-1:0] high,
  output logic [AW-1:0] sum,
  output logic          carry,
  output logic          below,
  output logic          above,
  output logic          err
);
  function automatic logic [AW:0] add_wide(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic outside(input logic [AW-1:0] v, input logic [AW-1:0] lo,
                                   input logic [AW-1:0] hi);
    return (v < lo) || (v > hi);
  endfunction

  logic [AW:0] wide;

  always_comb begin
    wide  = add_wide(laddr, base);
    sum   = wide[AW-1:0];
    carry = wide[AW];
    below = sum < low;
    above = sum > high;
    err   = carry || outside(sum, low, high);
  end
endmodule

// File: rtl/seg_resp_reg.sv
module seg_resp_reg
  import seg_xlate_pkg::*;
#(
  parameter int AW = ADDR_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] sum,
  input  logic          err,
  output logic          resp_valid,
  output logic [AW-1:0] phys_addr,
  output logic          range_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      phys_addr  <= '0;
      range_err  <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      range_err  <= req_valid && err;
      phys_addr  <= (req_valid && !err) ? sum : '0;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int AW = ADDR_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic [AW-1:0] req_laddr,
  output logic          resp_valid,
  output logic [AW-1:0] phys_addr,
  output logic          range_err
);
  logic [AW-1:0] base_w, low_w, high_w, sum_w;
  logic          carry_w, below_w, above_w, err_w;

  seg_desc_regs #(.AW(AW)) u_desc (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .base_o (base_w),
    .low_o  (low_w),
    .high_o (high_w)
  );

  seg_xlate_core #(.AW(AW)) u_core (
    .laddr (req_laddr),
    .base  (base_w),
    .low   (low_w),
    .high  (high_w),
    .sum   (sum_w),
    .carry (carry_w),
    .below (below_w),
    .above (above_w),
    .err   (err_w)
  );

  seg_resp_reg #(.AW(AW)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .sum        (sum_w),
    .err        (err_w),
    .resp_valid (resp_valid),
    .phys_addr  (phys_addr),
    .range_err  (range_err)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic          req_valid,
  input logic [AW-1:0] req_laddr,
  input logic          resp_valid,
  input logic [AW-1:0] phys_addr,
  input logic          range_err,
  input logic [AW-1:0] base_w,
  input logic [AW-1:0] low_w,
  input logic [AW-1:0] high_w,
  input logic          carry_w,
  input logic          below_w,
  input logic          above_w
);
  assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  assert_idle_outputs_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> (phys_addr == '0) && !range_err);

  assert_in_range_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !carry_w && !below_w && !above_w) |=>
      !range_err && (phys_addr == AW'($past(req_laddr) + $past(base_w))));

  assert_below_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && below_w) |=> range_err && (phys_addr == '0));

  assert_above_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && above_w) |=> range_err && (phys_addr == '0));

  assert_carry_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && carry_w) |=> range_err && (phys_addr == '0));

  assert_base_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd0) |=> base_w == $past(cfg_wdata));

  assert_null_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd3) |=> $stable(base_w) && $stable(low_w) && $stable(high_w));
endmodule

bind seg_xlate seg_xlate_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .cfg_wdata  (cfg_wdata),
  .req_valid  (req_valid),
  .req_laddr  (req_laddr),
  .resp_valid (resp_valid),
  .phys_addr  (phys_addr),
  .range_err  (range_err),
  .base_w     (base_w),
  .low_w      (low_w),
  .high_w     (high_w),
  .carry_w    (carry_w),
  .below_w    (below_w),
  .above_w    (above_w)
);

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
  localparam int AW = 32;
  localparam int NVEC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_laddr = '0;
  logic          resp_valid;
  logic [AW-1:0] phys_addr;
  logic          range_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  seg_xlate #(.AW(AW)) u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_laddr(req_laddr),
    .resp_valid(resp_valid), .phys_addr(phys_addr), .range_err(range_err)
  );

  // {base, lower, upper, laddr, expected phys, expected err}
  localparam logic [5*AW:0] VEC [NVEC] = '{
    {32'h0000_1000, 32'h0000_1000, 32'h0000_1FFF, 32'h0000_0010, 32'h0000_1010, 1'b0}, // R3
    {32'h0000_1000, 32'h0000_1000, 32'h0000_1FFF, 32'h0000_0000, 32'h0000_1000, 1'b0}, // R4 low edge
    {32'h0000_1000, 32'h0000_1000, 32'h0000_1FFF, 32'h0000_0FFF, 32'h0000_1FFF, 1'b0}, // R4 high edge
    {32'h0000_1000, 32'h0000_1000, 32'h0000_1FFF, 32'h0000_1000, 32'h0000_0000, 1'b1}, // R6
    {32'h0000_0000, 32'h0000_0100, 32'hFFFF_FFFF, 32'h0000_00FF, 32'h0000_0000, 1'b1}, // R5
    {32'hF000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1000_0000, 32'h0000_0000, 1'b1}, // R7
    {32'hF000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0FFF_FFFF, 32'hFFFF_FFFF, 1'b0}, // R3/R4 top
    {32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b1}  // R10
  };

  task automatic check(input string req, input logic act_v, input logic exp_v,
                       input logic [AW-1:0] act_p, input logic [AW-1:0] exp_p,
                       input logic act_e, input logic exp_e);
    n_checks++;
    if (act_v !== exp_v || act_p !== exp_p || act_e !== exp_e) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b phys=%h err=%0b, expected valid=%0b phys=%h err=%0b",
               req, act_v, act_p, act_e, exp_v, exp_p, exp_e);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // issue one request, sample its response one cycle later
  task automatic xlate(input logic [AW-1:0] la);
    @(negedge clk);
    req_valid = 1'b1; req_laddr = la;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset outputs", resp_valid, 1'b0, phys_addr, '0, range_err, 1'b0);
    xlate(32'h1234_5678);
    check("R1 reset descriptor", resp_valid, 1'b1, phys_addr, 32'h1234_5678, range_err, 1'b0);
    @(negedge clk);
    check("R2 idle", resp_valid, 1'b0, phys_addr, '0, range_err, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, VEC[i][5*AW:4*AW+1]);
      wr(2'd1, VEC[i][4*AW:3*AW+1]);
      wr(2'd2, VEC[i][3*AW:2*AW+1]);
      xlate(VEC[i][2*AW:AW+1]);
      check($sformatf("R3-table vector %0d (R4 R5 R6 R7 R10)", i), resp_valid, 1'b1,
            phys_addr, VEC[i][AW:1], range_err, VEC[i][0]);
    end

    // R8: same-cycle write uses old base, next cycle new base
    wr(2'd0, 32'h0); wr(2'd1, 32'h0); wr(2'd2, 32'hFFFF_FFFF);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h0000_0100;
    req_valid = 1'b1; req_laddr = 32'h10;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R8 same-cycle old base", resp_valid, 1'b1, phys_addr, 32'h10, range_err, 1'b0);
    req_laddr = 32'h10;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 next-cycle new base; R2 back-to-back", resp_valid, 1'b1, phys_addr, 32'h110,
          range_err, 1'b0);

    // R8: limit write takes effect on next request
    wr(2'd2, 32'h0000_0150);
    xlate(32'h60);
    check("R8 upper write", resp_valid, 1'b1, phys_addr, '0, range_err, 1'b1);

    // R9: select code 3 changes nothing
    wr(2'd3, 32'h0000_0000);
    xlate(32'h50);
    check("R9 null write", resp_valid, 1'b1, phys_addr, 32'h150, range_err, 1'b0);
    xlate(32'h00);
    check("R9 null write lower kept", resp_valid, 1'b1, phys_addr, 32'h100, range_err, 1'b0);

    // R1: reset restores identity descriptor
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 second reset outputs", resp_valid, 1'b0, phys_addr, '0, range_err, 1'b0);
    xlate(32'hFFFF_FFFF);
    check("R1 identity after reset", resp_valid, 1'b1, phys_addr, 32'hFFFF_FFFF, range_err, 1'b0);

    finish_run();
  end
endmodule